// File: doc/BRIEF.md
# Cache-Line Encoder with Folded Checksum and Symbol ECC

This block turns one 64-byte cache line into the protected form that is written to a rank of nineteen 4-bit-wide memory devices. It first computes a 32-bit CRC over the line. When address binding is switched on, the CRC also covers the eight bytes of the request address. The address itself is never written out. The line is cut into four blocks of sixteen byte symbols, and each block takes one byte of the CRC as a seventeenth symbol. Every 17-symbol block then receives two Reed-Solomon check symbols over GF(2^8). The checksum therefore sits inside the correctable part of the codeword, and a later single-symbol repair covers it as well.

The line arrives on a valid/ready input channel. The encoded result leaves as eight 76-bit beats on a valid/ready output channel. Each codeword is spread over two consecutive beats. A line is taken only when the output side can make room for it. While a line is draining, the input stays stalled, except on the cycle in which its final beat is taken. On that cycle a new line may enter with no bubble between lines. A stalled output holds its beat unchanged. The address-binding select is a plain level pin. It is sampled together with the line.

Top module: `ecl_line_encoder`

## Requirements
- R1: `in_ready` is high when no beat is pending, and on a cycle where the final beat of a line is being taken (`out_valid`, `out_ready` and `out_last` all high). It is low on every other cycle. A line is accepted on a rising clock edge where `in_valid` and `in_ready` are both high.
- R2: Each accepted line yields exactly eight output beats, taken in order. `out_last` is high only on the eighth. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_beat` and `out_last` keep their values.
- R3: The first beat of a line is presented (`out_valid` high, `out_last` low) in the cycle after the line is accepted.
- R4: Codeword k (k = 0..3) carries line bytes 16k to 16k+15 as its symbols 0 to 15, in ascending order. Line byte b is `in_data[8b+7:8b]`.
- R5: The checksum is a reflected CRC-32 with polynomial 0x82F63B78, initial value 0xFFFFFFFF and a final inversion. Each byte is fed least significant bit first. Line bytes 0..63 go in first. When `addr_en` is high, address bytes 0..7 follow, where address byte b is `in_addr[8b+7:8b]`.
- R6: When `addr_en` is low, `in_addr` has no effect on any output beat.
- R7: Symbol 16 of codeword k is CRC byte k, that is `crc[8k+7:8k]`.
- R8: Symbols 17 and 18 of each codeword are its check symbols. They are chosen so that the polynomial with symbol i as the coefficient of x^(18-i) is zero at alpha and at alpha^2. The field is GF(256) built from x^8+x^4+x^3+x^2+1, and alpha = 2.
- R9: Codeword k occupies beats 2k and 2k+1. Symbol d is carried on lanes 4d to 4d+3. Lane 4d+p carries symbol bit 2p on the first beat of the pair and bit 2p+1 on the second.
- R10: While `rst_n` is low and after it is released, with no line yet accepted, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_en | input | 1 | Include the address bytes in the checksum |
| in_valid | input | 1 | Line offered |
| in_ready | output | 1 | Line can be taken |
| in_data | input | 512 | Cache line, byte b at bits 8b+7:8b |
| in_addr | input | 64 | Request address, byte b at bits 8b+7:8b |
| out_valid | output | 1 | Beat offered |
| out_ready | input | 1 | Beat taken by the sink |
| out_beat | output | 76 | Encoded beat, lane 4d+p is pin p of device d |
| out_last | output | 1 | Marks the eighth beat of a line |

## Verification
The properties assume that a source keeps `in_valid`, `in_data`, `in_addr` and `addr_en` steady from the moment it raises `in_valid` until the line is taken. They also assume that `out_ready` is a free choice of the sink and does not depend on `out_valid` in the same cycle. The stimulus keeps to these rules. It drives the line fields once, away from the clock edge, and holds them until the handshake. It changes `out_ready` only just after an edge, using three patterns: always ready, randomly ready, and mostly stalled. These patterns exercise the stall hold, the last-beat overlap with a following line, and the idle gap between lines.

// File: rtl/ecl_pkg.sv
`timescale 1ns/1ps
package ecl_pkg;
  localparam int SYM_W      = 8;
  localparam int DATA_SYMS  = 16;
  localparam int NUM_CW     = 4;
  localparam int CHK_SYMS   = 2;
  localparam int INFO_SYMS  = DATA_SYMS + 1;
  localparam int CW_SYMS    = INFO_SYMS + CHK_SYMS;
  localparam int PINS       = 4;
  localparam int BUS_W      = CW_SYMS * PINS;
  localparam int BEATS      = 2 * NUM_CW;
  localparam int LINE_BYTES = DATA_SYMS * NUM_CW;
  localparam int ADDR_BYTES = 8;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h82F63B78;
  localparam logic [SYM_W-1:0] GF_LOW   = 8'h1D;
  localparam logic [SYM_W-1:0] ALPHA    = 8'h02;

  typedef logic [SYM_W-1:0] sym_t;

  // Multiply in GF(256) modulo x^8+x^4+x^3+x^2+1.
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ GF_LOW) : (sh << 1);
    end
    return acc;
  endfunction

  // Advance a reflected CRC register by one byte, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input sym_t b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < SYM_W; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ecl_crc_unit.sv
`timescale 1ns/1ps
module ecl_crc_unit
  import ecl_pkg::*;
#(
  parameter int N_DATA = LINE_BYTES,
  parameter int N_ADDR = ADDR_BYTES
) (
  input  logic [N_DATA*SYM_W-1:0] data,
  input  logic [N_ADDR*SYM_W-1:0] addr,
  input  logic                    addr_en,
  output logic [CRC_W-1:0]        crc
);
  always_comb begin
    logic [CRC_W-1:0] c;
    c = '1;
    for (int b = 0; b < N_DATA; b++) c = crc_step(c, data[b*SYM_W +: SYM_W]);
    if (addr_en) begin
      for (int b = 0; b < N_ADDR; b++) c = crc_step(c, addr[b*SYM_W +: SYM_W]);
    end
    crc = ~c;
  end
endmodule

// File: rtl/ecl_rs_enc.sv
`timescale 1ns/1ps
module ecl_rs_enc
  import ecl_pkg::*;
#(
  parameter int K = INFO_SYMS
) (
  input  logic [K-1:0][SYM_W-1:0] info,
  output logic [1:0][SYM_W-1:0]   par
);
  // Generator (x + a)(x + a^2) = x^2 + G1 x + G0.
  localparam sym_t A2 = gf_mul(ALPHA, ALPHA);
  localparam sym_t G1 = ALPHA ^ A2;
  localparam sym_t G0 = gf_mul(ALPHA, A2);

  always_comb begin
    sym_t r1;
    sym_t r0;
    sym_t fb;
    r1 = '0;
    r0 = '0;
    for (int j = 0; j < K; j++) begin
      fb = info[j] ^ r1;
      r1 = r0 ^ gf_mul(fb, G1);
      r0 = gf_mul(fb, G0);
    end
    par[1] = r1;
    par[0] = r0;
  end
endmodule

// File: rtl/ecl_beat_pack.sv
`timescale 1ns/1ps
module ecl_beat_pack
  import ecl_pkg::*;
#(
  parameter int N_SYM = CW_SYMS,
  parameter int N_PIN = PINS,
  localparam int W    = N_SYM * N_PIN
) (
  input  logic [N_SYM-1:0][SYM_W-1:0] cw,
  output logic [W-1:0]                beat_a,
  output logic [W-1:0]                beat_b
);
  for (genvar d = 0; d < N_SYM; d++) begin : g_dev
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      assign beat_a[d*N_PIN + p] = cw[d][2*p];
      assign beat_b[d*N_PIN + p] = cw[d][2*p + 1];
    end
  end
endmodule

// File: rtl/ecl_line_encoder.sv
`timescale 1ns/1ps
module ecl_line_encoder
  import ecl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_en,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LINE_BYTES*SYM_W-1:0]   in_data,
  input  logic [ADDR_BYTES*SYM_W-1:0]   in_addr,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BUS_W-1:0]              out_beat,
  output logic                          out_last
);
  localparam int IDX_W = $clog2(BEATS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [CRC_W-1:0]              crc;
  logic [BEATS-1:0][BUS_W-1:0]   beats_nxt;
  logic [BEATS-1:0][BUS_W-1:0]   beat_q;
  logic                          busy;
  logic [IDX_W-1:0]              idx;
  logic                          accept;

  ecl_crc_unit u_crc (
    .data    (in_data),
    .addr    (in_addr),
    .addr_en (addr_en),
    .crc     (crc)
  );

  for (genvar k = 0; k < NUM_CW; k++) begin : g_cw
    logic [INFO_SYMS-1:0][SYM_W-1:0] info;
    logic [1:0][SYM_W-1:0]           par;
    logic [CW_SYMS-1:0][SYM_W-1:0]   cw;

    for (genvar j = 0; j < DATA_SYMS; j++) begin : g_sym
      assign info[j] = in_data[(k*DATA_SYMS + j)*SYM_W +: SYM_W];
    end
    assign info[DATA_SYMS] = crc[k*SYM_W +: SYM_W];

    ecl_rs_enc u_rs (
      .info (info),
      .par  (par)
    );

    assign cw[INFO_SYMS-1:0] = info;
    assign cw[CW_SYMS-2]     = par[1];
    assign cw[CW_SYMS-1]     = par[0];

    ecl_beat_pack u_pack (
      .cw     (cw),
      .beat_a (beats_nxt[2*k]),
      .beat_b (beats_nxt[2*k + 1])
    );
  end

  assign in_ready  = !busy || (out_ready && idx == LAST_IDX);
  assign accept    = in_valid && in_ready;
  assign out_valid = busy;
  assign out_beat  = beat_q[idx];
  assign out_last  = busy && idx == LAST_IDX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      beat_q <= '0;
    end else if (accept) begin
      beat_q <= beats_nxt;
      busy   <= 1'b1;
      idx    <= '0;
    end else if (busy && out_ready) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/ecl_line_encoder_chk.sv
`timescale 1ns/1ps
module ecl_line_encoder_chk
  import ecl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BUS_W-1:0] out_beat,
  input logic             out_last
);
  localparam int CW = $clog2(BEATS);
  logic [CW-1:0] taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken <= '0;
    else if (out_valid && out_ready) taken <= taken + 1'b1;
  end

  // R2
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_beat) && $stable(out_last));

  // R1
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && out_last) |-> !in_ready);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !out_last);

  // R2
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (taken == CW'(BEATS - 1))));

  // R2
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !(in_valid && in_ready) |=> !out_valid);
endmodule

bind ecl_line_encoder ecl_line_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_beat  (out_beat),
  .out_last  (out_last)
);

// File: tb/sim_ecl_line_encoder.sv
`timescale 1ns/1ps
module sim_ecl_line_encoder;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_en = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [511:0]  in_data = '0;
  logic [63:0]   in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [75:0]   out_beat;
  logic          out_last;

  always #2 clk = ~clk;

  ecl_line_encoder u0 (
    .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_beat(out_beat),
    .out_last(out_last)
  );

  typedef struct {
    logic [511:0] data;
    logic [31:0]  crc;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int lines_seen = 0;
  int rdy_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [511:0] d, input logic [63:0] a,
                                          input bit use_a);
    logic [31:0] c = 32'hFFFFFFFF;
    int n = use_a ? 72 : 64;
    for (int b = 0; b < n; b++) begin
      logic [7:0] by = (b < 64) ? d[b*8 +: 8] : a[(b-64)*8 +: 8];
      for (int i = 0; i < 8; i++) begin
        bit mix = c[0] ^ by[i];
        c = c >> 1;
        if (mix) c ^= 32'h82F63B78;
      end
    end
    return ~c;
  endfunction

  // R5 R6: expected checksum computed here; with addr_en low the address is left out.
  task automatic push(input logic [511:0] d, input logic [63:0] a, input bit use_a);
    exp_t e;
    @(negedge clk);
    in_data = d; in_addr = a; addr_en = use_a; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e.data = d; e.crc = ref_crc(d, a, use_a);
    q.push_back(e);
    pushed++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_addr = ~a;
    // R3: first beat visible right after acceptance
    check(out_valid === 1'b1, "R3", "out_valid after accept", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic compare_line(input logic [7:0][75:0] got);
    exp_t e;
    lines_seen++;
    if (q.size() == 0) begin
      check(1'b0, "R2", "unexpected line", 64'd1, 64'd0);
      return;
    end
    e = q.pop_front();
    for (int k = 0; k < 4; k++) begin
      logic [18:0][7:0] s;
      logic [7:0] s1, s2;
      for (int d = 0; d < 19; d++)
        for (int p = 0; p < 4; p++) begin
          s[d][2*p]   = got[2*k][4*d + p];
          s[d][2*p+1] = got[2*k+1][4*d + p];
        end
      for (int j = 0; j < 16; j++)
        check(s[j] === e.data[(16*k + j)*8 +: 8], "R4 R9", "data symbol",
              {56'd0, s[j]}, {56'd0, e.data[(16*k + j)*8 +: 8]});
      check(s[16] === e.crc[8*k +: 8], "R7 R5", "checksum symbol",
            {56'd0, s[16]}, {56'd0, e.crc[8*k +: 8]});
      s1 = 8'h00; s2 = 8'h00;
      for (int i = 0; i < 19; i++) begin
        s1 = fmul(s1, 8'h02) ^ s[i];
        s2 = fmul(s2, 8'h04) ^ s[i];
      end
      check(s1 === 8'h00 && s2 === 8'h00, "R8 R9", "syndromes",
            {48'd0, s1, s2}, 64'd0);
    end
  endtask

  initial begin : monitor
    logic [7:0][75:0] got;
    int n = 0;
    bit stalled = 1'b0;
    logic [75:0] held_beat = '0;
    logic held_last = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      // R1: ready follows the pending-beat rule
      check(in_ready === (!out_valid || (out_ready && out_last)), "R1", "in_ready",
            {63'd0, in_ready}, {63'd0, (!out_valid || (out_ready && out_last))});
      if (stalled) begin
        // R2: stalled beat held
        check(out_valid === 1'b1 && out_beat === held_beat && out_last === held_last,
              "R2", "stall hold", out_beat[63:0], held_beat[63:0]);
      end
      stalled = out_valid && !out_ready;
      held_beat = out_beat;
      held_last = out_last;
      if (out_valid && out_ready) begin
        // R2: last flag on eighth beat only
        check(out_last === (n == 7), "R2", "out_last position",
              {63'd0, out_last}, {63'd0, (n == 7)});
        got[n] = out_beat;
        n++;
        if (n == 8) begin
          compare_line(got);
          n = 0;
        end
      end
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 2) == 0;
        default: out_ready = ($urandom % 5) == 0;
      endcase
    end
  end

  function automatic logic [511:0] rnd_line();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin : stim
    logic [511:0] d;
    #1;
    // R10: reset state
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10", "during reset",
          {62'd0, out_valid, in_ready}, 64'd1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10", "after reset",
          {62'd0, out_valid, in_ready}, 64'd1);
    fork
      begin
        rdy_mode = 0;
        push('0, 64'h0, 1'b0);
        push('1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        for (int i = 0; i < 64; i++) d[i*8 +: 8] = 8'(i * 3 + 1);
        push(d, 64'h0123_4567_89AB_CDEF, 1'b1);
        // R6: same line, different addresses, address excluded
        d = rnd_line();
        push(d, 64'h1111_2222_3333_4444, 1'b0);
        push(d, 64'hDEAD_BEEF_0000_0001, 1'b0);
        // R5: same line with the address included
        push(d, 64'hDEAD_BEEF_0000_0001, 1'b1);
        rdy_mode = 1;
        for (int i = 0; i < 6; i++) push(rnd_line(), {$urandom, $urandom}, 1'(i % 2));
        rdy_mode = 2;
        for (int i = 0; i < 4; i++) push(rnd_line(), {$urandom, $urandom}, 1'(i % 2));
        rdy_mode = 0;
        for (int i = 0; i < 3; i++) push(rnd_line(), {$urandom, $urandom}, 1'b1);
        while (lines_seen < pushed) @(negedge clk);
        repeat (4) @(negedge clk);
        check(q.size() == 0 && out_valid === 1'b0, "R2", "all lines drained",
              {32'd0, 32'(q.size())}, 64'd0);
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 64'(lines_seen), 64'(pushed));
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule